// File: doc/BRIEF.md
# Link Reset Classifier and Width/Frequency Keeper

This block sits at the reset boundary of a point-to-point link port. It watches two inputs: a power-good level and an active-low link reset. From them it decides whether the port is in a cold reset, a warm reset or normal running. The raw inputs pass through a synchronizer before the decision. The block holds the link input width, output width and frequency settings in two copies. Software writes the programmed copy. The active copy governs the link and is refreshed only when a reset ends.

A warm reset keeps every programmed setting. When the reset ends, those settings become active. A cold reset returns both copies to their defaults. While either reset is held, the block drives the control lane low and drives a run of ones on the low command/address/data lanes. The length of that run is the programmed output width during a warm reset and the default width during a cold reset. Any reset clears the assigned unit identifier. When a reset ends, a one-cycle start pulse hands off to the clock synchronization logic outside this block.

Top module: `link_reset_keeper`

## Requirements
- R1: After the synchronizer (state changes on the third rising edge after an input change), `in_cold` is 1 when `pwr_good_i` is 0. `in_warm` is 1 when `pwr_good_i` is 1 and `link_rst_n_i` is 0. Both are 0 when both inputs are 1.
- R2: A warm reset leaves the programmed width and frequency fields unchanged and leaves the active fields at their earlier values. When the reset ends, the active fields take the programmed values on the same edge that raises `sync_start`.
- R3: A cold reset sets all programmed and active fields to 0: width code 0 is 8 lanes, and frequency code 0 is the lowest. Configuration writes made while in cold reset are ignored.
- R4: During a warm reset, `ctl_out` is 0. `cad_out` bits below the lane count of the programmed output width code are 1, and the bits at or above it are 0. Width codes: 0=8, 1=16, 2=32, 3=2, 4=4 lanes. The pattern follows writes made during the reset.
- R5: During a cold reset, `ctl_out` is 0 and `cad_out` has bits 7:0 at 1 and all other bits at 0.
- R6: Outside reset, `ctl_out` equals `tx_ctl` and `cad_out` equals `tx_cad`.
- R7: Entering any reset clears `unit_id` to 0. Unit identifier writes are ignored while in reset and take effect in running state.
- R8: `sync_start` is high for exactly one cycle, in the first cycle of running state after a warm or a cold reset.
- R9: While running, configuration writes go to the programmed fields only: address 0 is input width, 1 is output width, 2 is frequency. Address 3 is ignored. The active fields do not change.
- R10: Output width codes 5, 6 and 7 drive the reset lane pattern as 8 lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low block reset (forces cold state) |
| pwr_good_i | input | 1 | Raw power-good level |
| link_rst_n_i | input | 1 | Raw active-low link reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_addr | input | 2 | Field select: 0 in-width, 1 out-width, 2 frequency |
| cfg_wr_data | input | FREQ_W | Write data (width codes use low 3 bits) |
| uid_wr_en | input | 1 | Unit identifier write strobe |
| uid_wr_data | input | UID_W | Unit identifier value |
| tx_ctl | input | 1 | Control lane value when running |
| tx_cad | input | CAD_W | Lane values when running |
| ctl_out | output | 1 | Driven control lane |
| cad_out | output | CAD_W | Driven command/address/data lanes |
| in_cold | output | 1 | Cold reset in progress |
| in_warm | output | 1 | Warm reset in progress |
| sync_start | output | 1 | One-cycle synchronization start pulse |
| prog_width_in | output | 3 | Programmed input width code |
| prog_width_out | output | 3 | Programmed output width code |
| prog_freq | output | FREQ_W | Programmed frequency code |
| act_width_in | output | 3 | Active input width code |
| act_width_out | output | 3 | Active output width code |
| act_freq | output | FREQ_W | Active frequency code |
| unit_id | output | UID_W | Assigned unit identifier |

## Verification
The hardest case to reach is a warm reset during which the output width is rewritten while the active copy must stay put. The stimulus holds the link reset low with power good, writes several width codes, including an out-of-range one, and checks the lane pattern after each write. It then releases the reset and confirms that the pulse and the activation happen on the same cycle. A second case drops power good during a warm reset so that a cold reset pre-empts it. A third releases both inputs at the same moment to confirm that cold exit raises the same pulse.

// File: rtl/lrk_pkg.sv
package lrk_pkg;
  localparam int WC_W = 3;   // width code field size
  localparam int DEF_LANES = 8;

  typedef enum logic [1:0] {
    ST_COLD = 2'd0,
    ST_WARM = 2'd1,
    ST_RUN  = 2'd2
  } rst_state_e;

  typedef enum logic [1:0] {
    A_WIN  = 2'd0,
    A_WOUT = 2'd1,
    A_FREQ = 2'd2,
    A_RSVD = 2'd3
  } cfg_addr_e;

  // lane count for a width code; unknown codes fall back to 8
  function automatic int lanes_of(input logic [WC_W-1:0] code);
    case (code)
      3'd0:    lanes_of = 8;
      3'd1:    lanes_of = 16;
      3'd2:    lanes_of = 32;
      3'd3:    lanes_of = 2;
      3'd4:    lanes_of = 4;
      default: lanes_of = DEF_LANES;
    endcase
  endfunction
endpackage

// File: rtl/lrk_sync.sv
module lrk_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      logic [WIDTH-1:0] src;
      if (g == 0) begin : g_first
        assign src = d_i;
      end else begin : g_next
        assign src = stg_q[g-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[g] <= '0;
        else        stg_q[g] <= src;
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/lrk_fsm.sv
module lrk_fsm
  import lrk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pg_s,
  input  logic lr_n_s,
  output logic go_cold,
  output logic activate,
  output logic hold_uid,
  output logic in_cold,
  output logic in_warm,
  output logic in_reset,
  output logic sync_start
);
  rst_state_e state_q, state_n;
  logic       pulse_q, pulse_n;

  always_comb begin
    if (!pg_s)        state_n = ST_COLD;
    else if (!lr_n_s) state_n = ST_WARM;
    else              state_n = ST_RUN;
    activate = (state_q != ST_RUN) && (state_n == ST_RUN);
    pulse_n  = activate;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_COLD;
      pulse_q <= 1'b0;
    end else begin
      state_q <= state_n;
      pulse_q <= pulse_n;
    end
  end

  assign go_cold    = (state_n == ST_COLD);
  assign hold_uid   = (state_n != ST_RUN);
  assign in_cold    = (state_q == ST_COLD);
  assign in_warm    = (state_q == ST_WARM);
  assign in_reset   = (state_q != ST_RUN);
  assign sync_start = pulse_q;

  p_sync_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sync_start |=> !sync_start);
  p_sync_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sync_start |-> (state_q == ST_RUN));
endmodule

// File: rtl/lrk_cfg_regs.sv
module lrk_cfg_regs
  import lrk_pkg::*;
#(
  parameter int FREQ_W = 4,
  parameter int UID_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_cold,
  input  logic              activate,
  input  logic              hold_uid,
  input  logic              in_reset,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [FREQ_W-1:0] wr_data,
  input  logic              uid_wr_en,
  input  logic [UID_W-1:0]  uid_wr_data,
  output logic [WC_W-1:0]   prog_wi,
  output logic [WC_W-1:0]   prog_wo,
  output logic [FREQ_W-1:0] prog_f,
  output logic [WC_W-1:0]   act_wi,
  output logic [WC_W-1:0]   act_wo,
  output logic [FREQ_W-1:0] act_f,
  output logic [UID_W-1:0]  uid
);
  logic [WC_W-1:0]   pwi_q, pwi_n, pwo_q, pwo_n, awi_q, awi_n, awo_q, awo_n;
  logic [FREQ_W-1:0] pf_q, pf_n, af_q, af_n;
  logic [UID_W-1:0]  uid_q, uid_n;

  always_comb begin
    pwi_n = pwi_q; pwo_n = pwo_q; pf_n = pf_q;
    awi_n = awi_q; awo_n = awo_q; af_n = af_q;
    if (go_cold) begin
      pwi_n = '0; pwo_n = '0; pf_n = '0;
      awi_n = '0; awo_n = '0; af_n = '0;
    end else begin
      if (wr_en) begin
        case (wr_addr)
          A_WIN:   pwi_n = wr_data[WC_W-1:0];
          A_WOUT:  pwo_n = wr_data[WC_W-1:0];
          A_FREQ:  pf_n  = wr_data;
          default: ;
        endcase
      end
      if (activate) begin
        awi_n = pwi_q; awo_n = pwo_q; af_n = pf_q;
      end
    end
    if (hold_uid)       uid_n = '0;
    else if (uid_wr_en) uid_n = uid_wr_data;
    else                uid_n = uid_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwi_q <= '0; pwo_q <= '0; pf_q <= '0;
      awi_q <= '0; awo_q <= '0; af_q <= '0;
      uid_q <= '0;
    end else begin
      pwi_q <= pwi_n; pwo_q <= pwo_n; pf_q <= pf_n;
      awi_q <= awi_n; awo_q <= awo_n; af_q <= af_n;
      uid_q <= uid_n;
    end
  end

  assign prog_wi = pwi_q; assign prog_wo = pwo_q; assign prog_f = pf_q;
  assign act_wi  = awi_q; assign act_wo  = awo_q; assign act_f  = af_q;
  assign uid     = uid_q;

  p_act_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!activate && !go_cold) |=> $stable({awi_q, awo_q, af_q}));
  p_cold_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    go_cold |=> ({pwi_q, pwo_q, pf_q, awi_q, awo_q, af_q} == '0));
  p_uid_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_reset |-> (uid_q == '0));
endmodule

// File: rtl/lrk_lane_drv.sv
module lrk_lane_drv
  import lrk_pkg::*;
#(
  parameter int CAD_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_cold,
  input  logic             in_reset,
  input  logic [WC_W-1:0]  prog_wo,
  input  logic             tx_ctl,
  input  logic [CAD_W-1:0] tx_cad,
  output logic             ctl_out,
  output logic [CAD_W-1:0] cad_out
);
  logic [WC_W-1:0]  code_sel;
  int               n_lanes;
  logic [CAD_W-1:0] rst_pat;

  always_comb begin
    code_sel = in_cold ? '0 : prog_wo;   // code 0 is the default 8 lanes
    n_lanes  = lanes_of(code_sel);
  end

  genvar i;
  generate
    for (i = 0; i < CAD_W; i++) begin : g_lane
      assign rst_pat[i] = (i < n_lanes);
    end
  endgenerate

  always_comb begin
    ctl_out = in_reset ? 1'b0 : tx_ctl;
    cad_out = in_reset ? rst_pat : tx_cad;
  end

  p_ctl_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_reset && tx_ctl) |-> !ctl_out);
endmodule

// File: rtl/link_reset_keeper.sv
module link_reset_keeper
  import lrk_pkg::*;
#(
  parameter int CAD_W       = 32,
  parameter int FREQ_W      = 4,
  parameter int UID_W       = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_good_i,
  input  logic              link_rst_n_i,
  input  logic              cfg_wr_en,
  input  logic [1:0]        cfg_wr_addr,
  input  logic [FREQ_W-1:0] cfg_wr_data,
  input  logic              uid_wr_en,
  input  logic [UID_W-1:0]  uid_wr_data,
  input  logic              tx_ctl,
  input  logic [CAD_W-1:0]  tx_cad,
  output logic              ctl_out,
  output logic [CAD_W-1:0]  cad_out,
  output logic              in_cold,
  output logic              in_warm,
  output logic              sync_start,
  output logic [2:0]        prog_width_in,
  output logic [2:0]        prog_width_out,
  output logic [FREQ_W-1:0] prog_freq,
  output logic [2:0]        act_width_in,
  output logic [2:0]        act_width_out,
  output logic [FREQ_W-1:0] act_freq,
  output logic [UID_W-1:0]  unit_id
);
  logic [1:0] raw, synced;
  logic go_cold, activate, hold_uid, in_reset;

  assign raw = {pwr_good_i, link_rst_n_i};

  lrk_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(raw), .q_o(synced));

  lrk_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .pg_s(synced[1]), .lr_n_s(synced[0]),
    .go_cold(go_cold), .activate(activate), .hold_uid(hold_uid),
    .in_cold(in_cold), .in_warm(in_warm), .in_reset(in_reset),
    .sync_start(sync_start));

  lrk_cfg_regs #(.FREQ_W(FREQ_W), .UID_W(UID_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .go_cold(go_cold), .activate(activate),
    .hold_uid(hold_uid), .in_reset(in_reset),
    .wr_en(cfg_wr_en), .wr_addr(cfg_wr_addr), .wr_data(cfg_wr_data),
    .uid_wr_en(uid_wr_en), .uid_wr_data(uid_wr_data),
    .prog_wi(prog_width_in), .prog_wo(prog_width_out), .prog_f(prog_freq),
    .act_wi(act_width_in), .act_wo(act_width_out), .act_f(act_freq),
    .uid(unit_id));

  lrk_lane_drv #(.CAD_W(CAD_W)) u_lane (
    .clk(clk), .rst_n(rst_n), .in_cold(in_cold), .in_reset(in_reset),
    .prog_wo(prog_width_out), .tx_ctl(tx_ctl), .tx_cad(tx_cad),
    .ctl_out(ctl_out), .cad_out(cad_out));
endmodule

// File: tb/tb_link_reset_keeper.sv
module tb_link_reset_keeper;
  logic clk = 1'b0;
  logic rst_n, pwr_good_i, link_rst_n_i, cfg_wr_en, uid_wr_en, tx_ctl;
  logic [1:0]  cfg_wr_addr;
  logic [3:0]  cfg_wr_data;
  logic [4:0]  uid_wr_data;
  logic [31:0] tx_cad;
  logic        ctl_out, in_cold, in_warm, sync_start;
  logic [31:0] cad_out;
  logic [2:0]  prog_width_in, prog_width_out, act_width_in, act_width_out;
  logic [3:0]  prog_freq, act_freq;
  logic [4:0]  unit_id;

  always #2.5 clk = ~clk;   // 200 MHz

  link_reset_keeper dut (.*);

  typedef struct { string req; int fld; logic [31:0] exp; } item_t;
  item_t q[$];
  event  chk_ev;
  int    checks = 0, errors = 0;
  bit    done = 0;

  localparam int F_CTL = 0, F_CAD = 1, F_COLD = 2, F_WARM = 3, F_SYNC = 4,
                 F_PWI = 5, F_PWO = 6, F_PF = 7, F_AWI = 8, F_AWO = 9,
                 F_AF = 10, F_UID = 11;

  function automatic logic [31:0] observe(int f);
    case (f)
      F_CTL:  return {31'd0, ctl_out};
      F_CAD:  return cad_out;
      F_COLD: return {31'd0, in_cold};
      F_WARM: return {31'd0, in_warm};
      F_SYNC: return {31'd0, sync_start};
      F_PWI:  return {29'd0, prog_width_in};
      F_PWO:  return {29'd0, prog_width_out};
      F_PF:   return {28'd0, prog_freq};
      F_AWI:  return {29'd0, act_width_in};
      F_AWO:  return {29'd0, act_width_out};
      F_AF:   return {28'd0, act_freq};
      default: return {27'd0, unit_id};
    endcase
  endfunction

  // monitor: pops expected items and compares against the ports
  initial begin
    forever begin
      @(chk_ev);
      while (q.size() > 0) begin
        item_t it;
        logic [31:0] got;
        it  = q.pop_front();
        got = observe(it.fld);
        checks++;
        if (got !== it.exp) begin
          errors++;
          $display("FAIL %s field %0d actual %h expected %h", it.req, it.fld, got, it.exp);
        end
      end
    end
  end

  task automatic expect_(string req, int fld, logic [31:0] exp);
    item_t it;
    it.req = req; it.fld = fld; it.exp = exp;
    q.push_back(it);
  endtask

  task automatic flush();
    -> chk_ev;
    #0.5;
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg_write(logic [1:0] a, logic [3:0] d);
    cfg_wr_en = 1'b1; cfg_wr_addr = a; cfg_wr_data = d;
    tick(1);
    cfg_wr_en = 1'b0;
  endtask

  task automatic uid_write(logic [4:0] d);
    uid_wr_en = 1'b1; uid_wr_data = d;
    tick(1);
    uid_wr_en = 1'b0;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    rst_n = 0; pwr_good_i = 0; link_rst_n_i = 0;
    cfg_wr_en = 0; cfg_wr_addr = 0; cfg_wr_data = 0;
    uid_wr_en = 0; uid_wr_data = 0; tx_ctl = 1; tx_cad = 32'hA5A5_1234;
    tick(3);
    rst_n = 1;
    tick(2);
    // reset state: cold, defaults, default lane pattern
    expect_("R1", F_COLD, 1); expect_("R1", F_WARM, 0);
    expect_("R3", F_PWO, 0); expect_("R3", F_AF, 0);
    expect_("R5", F_CTL, 0); expect_("R5", F_CAD, 32'h0000_00FF);
    expect_("R7", F_UID, 0);
    flush();
    // write while cold is ignored
    cfg_write(2'd1, 4'd1);
    expect_("R3", F_PWO, 0); flush();

    // enter warm
    pwr_good_i = 1; tick(3);
    expect_("R1", F_WARM, 1); expect_("R1", F_COLD, 0);
    expect_("R4", F_CAD, 32'h0000_00FF); expect_("R4", F_CTL, 0);
    flush();

    // exit warm to run
    link_rst_n_i = 1; tick(3);
    expect_("R8", F_SYNC, 1); expect_("R1", F_WARM, 0); flush();
    tick(1);
    expect_("R8", F_SYNC, 0);
    expect_("R6", F_CTL, 1); expect_("R6", F_CAD, 32'hA5A5_1234);
    flush();

    // running writes
    uid_write(5'd5);
    expect_("R7", F_UID, 5); flush();
    cfg_write(2'd0, 4'd2); cfg_write(2'd1, 4'd1); cfg_write(2'd2, 4'd9);
    cfg_write(2'd3, 4'd7);
    expect_("R9", F_PWI, 2); expect_("R9", F_PWO, 1); expect_("R9", F_PF, 9);
    expect_("R9", F_AWI, 0); expect_("R9", F_AWO, 0); expect_("R9", F_AF, 0);
    flush();

    // warm reset
    link_rst_n_i = 0; tick(3);
    expect_("R1", F_WARM, 1); expect_("R7", F_UID, 0);
    expect_("R4", F_CTL, 0); expect_("R4", F_CAD, 32'h0000_FFFF);
    expect_("R2", F_PWI, 2); expect_("R2", F_PWO, 1); expect_("R2", F_PF, 9);
    expect_("R2", F_AWO, 0); expect_("R2", F_AF, 0);
    flush();
    uid_write(5'd9);
    expect_("R7", F_UID, 0); flush();
    cfg_write(2'd1, 4'd4); expect_("R4", F_CAD, 32'h0000_000F); flush();
    cfg_write(2'd1, 4'd3); expect_("R4", F_CAD, 32'h0000_0003); flush();
    cfg_write(2'd1, 4'd6); expect_("R10", F_CAD, 32'h0000_00FF); flush();
    cfg_write(2'd1, 4'd7); expect_("R10", F_CAD, 32'h0000_00FF); flush();
    cfg_write(2'd1, 4'd2); expect_("R4", F_CAD, 32'hFFFF_FFFF); flush();
    expect_("R2", F_AWO, 0); flush();

    // warm exit activates programmed values
    link_rst_n_i = 1; tick(3);
    expect_("R8", F_SYNC, 1);
    expect_("R2", F_AWI, 2); expect_("R2", F_AWO, 2); expect_("R2", F_AF, 9);
    flush();
    tick(1);
    expect_("R8", F_SYNC, 0); flush();

    // warm pre-empted by cold
    link_rst_n_i = 0; tick(3);
    expect_("R1", F_WARM, 1); flush();
    pwr_good_i = 0; tick(3);
    expect_("R1", F_COLD, 1); expect_("R1", F_WARM, 0);
    expect_("R3", F_PWI, 0); expect_("R3", F_PWO, 0); expect_("R3", F_PF, 0);
    expect_("R3", F_AWI, 0); expect_("R3", F_AWO, 0); expect_("R3", F_AF, 0);
    expect_("R5", F_CAD, 32'h0000_00FF); expect_("R5", F_CTL, 0);
    flush();

    // cold exit: both inputs released together
    pwr_good_i = 1; link_rst_n_i = 1; tick(3);
    expect_("R8", F_SYNC, 1); expect_("R1", F_COLD, 0);
    expect_("R6", F_CAD, 32'hA5A5_1234); flush();
    tick(1);
    expect_("R8", F_SYNC, 0); flush();

    done = 1;
    summary();
  end
endmodule